// File: doc/BRIEF.md
# Privileged Instruction Permission Checker

This block sits beside instruction decode and rules on whether a decoded instruction may proceed. Each cycle it may receive one instruction class, the current privilege level, a debug-register number and a set of feature-control enables. It returns a one-hot verdict: allow, invalid-opcode fault or protection fault. With it comes an effective debug-register index, in which the two legacy alias numbers are redirected when the debugging extensions are off. The counters, debug registers and media units themselves live elsewhere. The checker only arbitrates permission.

The verdict is registered. A two-state machine marks when a registered result is on the outputs.

- `ST_IDLE`: no result is presented.
- `ST_REPORT`: `out_valid` is high and the verdict belongs to the input accepted on the previous edge.

The transitions are:

- `ST_IDLE` to `ST_REPORT` on `in_valid` (named *accept*).
- `ST_REPORT` to `ST_REPORT` on `in_valid` (named *stream*).
- `ST_REPORT` to `ST_IDLE` when `in_valid` is low (named *drain*).
- `ST_IDLE` to `ST_IDLE` when `in_valid` is low (named *hold*).

Reset enters `ST_IDLE`.

Top module: `privop_permit_chk`

## Requirements
- R1: Each clock edge with `in_valid` high produces exactly one result with `out_valid` high in the following cycle. With no input, `out_valid` is low. After reset `out_valid` is low.
- R2: `out_verdict` is one-hot while `out_valid` is high: bit 0 means allow, bit 1 means invalid-opcode, bit 2 means protection fault.
- R3: Class encodings on `in_class` are 0 plain, 1 time-stamp read, 2 counter read, 3 debug-register access, 4 wide media, 5 media FP exception, 6 virtualization, 7 fast system call. Class 0 is always allowed.
- R4: A time-stamp read is allowed at any privilege when `in_ts_lock` is 0. When `in_ts_lock` is 1 it is allowed only at privilege 0, and otherwise yields a protection fault.
- R5: A counter read is allowed at any privilege when `in_ctr_open` is 1. When `in_ctr_open` is 0 it is allowed only at privilege 0, and otherwise yields a protection fault.
- R6: A debug-register access to register 4 or 5 yields invalid-opcode when `in_dbg_ext` is 1. Any other debug-register access is allowed with its index unchanged.
- R7: When `in_dbg_ext` is 0, a debug-register access is allowed and register 4 maps to 6 and register 5 to 7. Every other index, and the index of every non-debug class, passes through unchanged.
- R8: A wide media instruction yields invalid-opcode when `in_media_save` is 0, and is allowed when it is 1.
- R9: An unmasked media FP exception yields invalid-opcode when `in_fpx_ok` is 0. When `in_fpx_ok` is 1 it is allowed, which leaves the normal SIMD fault path to downstream logic.
- R10: A virtualization instruction yields invalid-opcode when `in_virt_en` is 0, and is allowed when it is 1.
- R11: A fast system call or return yields invalid-opcode when `in_fastcall_en` is 0, and is allowed when it is 1.
- R12: The privilege level affects only classes 1 and 2. Each enable input affects only its own class. Invalid-opcode outranks a protection fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input qualifier |
| in_class | input | 3 | Instruction class (R3 encoding) |
| in_cpl | input | CPL_W | Current privilege level, 0 most privileged |
| in_dbg_idx | input | DBG_W | Debug register number |
| in_ts_lock | input | 1 | Time-stamp reads restricted to privilege 0 |
| in_ctr_open | input | 1 | Counter reads open to every privilege |
| in_dbg_ext | input | 1 | Debugging extensions on |
| in_media_save | input | 1 | Wide media save/restore supported |
| in_fpx_ok | input | 1 | Unmasked SIMD FP fault handler present |
| in_virt_en | input | 1 | Virtualization instructions enabled |
| in_fastcall_en | input | 1 | Fast system call/return enabled |
| out_valid | output | 1 | Result qualifier |
| out_verdict | output | 3 | One-hot verdict (R2 encoding) |
| out_dbg_idx | output | DBG_W | Effective debug register number |

## Verification
A stuck or wrong state bit shows up as `out_valid` missing, or present with no input behind it, one cycle after the input edge. The scoreboard sees this at once as a missing or unexpected result. A wrong verdict or index register is caught on the very result it corrupts. Every class is driven at every privilege level under several enable patterns, so a gate tied to the wrong control or to the wrong class changes at least one compared verdict.

// File: rtl/privop_pkg.sv
package privop_pkg;

    typedef enum logic [2:0] {
        IC_PLAIN      = 3'd0,
        IC_TSC_RD     = 3'd1,
        IC_PMC_RD     = 3'd2,
        IC_DBG_MOV    = 3'd3,
        IC_WIDE_MEDIA = 3'd4,
        IC_MEDIA_FPX  = 3'd5,
        IC_VIRT       = 3'd6,
        IC_FAST_CALL  = 3'd7
    } iclass_e;

    typedef enum logic [2:0] {
        VD_ALLOW = 3'b001,
        VD_UD    = 3'b010,
        VD_PF    = 3'b100
    } verdict_e;

    typedef enum logic {
        ST_IDLE,
        ST_REPORT
    } chk_state_e;

endpackage

// File: rtl/privop_priv_gate.sv
module privop_priv_gate
    import privop_pkg::*;
#(
    parameter int CPL_W = 2
) (
    input  iclass_e            cls,
    input  logic [CPL_W-1:0]   cpl,
    input  logic               ts_lock,
    input  logic               ctr_open,
    output logic               deny
);
    logic not_ring0;

    always_comb begin
        not_ring0 = (cpl != '0);
        deny      = 1'b0;
        unique case (cls)
            IC_TSC_RD: deny = ts_lock && not_ring0;
            IC_PMC_RD: deny = !ctr_open && not_ring0;
            default:   deny = 1'b0;
        endcase
    end
endmodule

// File: rtl/privop_feat_gate.sv
module privop_feat_gate
    import privop_pkg::*;
#(
    parameter int DBG_W = 3
) (
    input  iclass_e            cls,
    input  logic [DBG_W-1:0]   dbg_idx,
    input  logic               dbg_ext,
    input  logic               media_save,
    input  logic               fpx_ok,
    input  logic               virt_en,
    input  logic               fastcall_en,
    output logic               undef,
    output logic [DBG_W-1:0]   dbg_eff
);
    localparam logic [DBG_W-1:0] ALIAS_A = DBG_W'(4);
    localparam logic [DBG_W-1:0] ALIAS_B = DBG_W'(5);
    localparam logic [DBG_W-1:0] TGT_A   = DBG_W'(6);
    localparam logic [DBG_W-1:0] TGT_B   = DBG_W'(7);

    logic is_alias;

    always_comb begin
        is_alias = (dbg_idx == ALIAS_A) || (dbg_idx == ALIAS_B);
        undef    = 1'b0;
        dbg_eff  = dbg_idx;
        unique case (cls)
            IC_DBG_MOV: begin
                if (dbg_ext) begin
                    undef = is_alias;
                end else if (dbg_idx == ALIAS_A) begin
                    dbg_eff = TGT_A;
                end else if (dbg_idx == ALIAS_B) begin
                    dbg_eff = TGT_B;
                end
            end
            IC_WIDE_MEDIA: undef = !media_save;
            IC_MEDIA_FPX:  undef = !fpx_ok;
            IC_VIRT:       undef = !virt_en;
            IC_FAST_CALL:  undef = !fastcall_en;
            default:       undef = 1'b0;
        endcase
    end
endmodule

// File: rtl/privop_permit_chk.sv
module privop_permit_chk
    import privop_pkg::*;
#(
    parameter int CPL_W = 2,
    parameter int DBG_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [2:0]         in_class,
    input  logic [CPL_W-1:0]   in_cpl,
    input  logic [DBG_W-1:0]   in_dbg_idx,
    input  logic               in_ts_lock,
    input  logic               in_ctr_open,
    input  logic               in_dbg_ext,
    input  logic               in_media_save,
    input  logic               in_fpx_ok,
    input  logic               in_virt_en,
    input  logic               in_fastcall_en,
    output logic               out_valid,
    output logic [2:0]         out_verdict,
    output logic [DBG_W-1:0]   out_dbg_idx
);
    iclass_e           cls;
    logic              priv_deny;
    logic              feat_undef;
    logic [DBG_W-1:0]  idx_eff;
    verdict_e          verdict_d;
    verdict_e          verdict_q;
    logic [DBG_W-1:0]  idx_q;
    chk_state_e        state_q;
    chk_state_e        state_d;

    assign cls = iclass_e'(in_class);

    privop_priv_gate #(.CPL_W(CPL_W)) priv_i (
        .cls      (cls),
        .cpl      (in_cpl),
        .ts_lock  (in_ts_lock),
        .ctr_open (in_ctr_open),
        .deny     (priv_deny)
    );

    privop_feat_gate #(.DBG_W(DBG_W)) feat_i (
        .cls         (cls),
        .dbg_idx     (in_dbg_idx),
        .dbg_ext     (in_dbg_ext),
        .media_save  (in_media_save),
        .fpx_ok      (in_fpx_ok),
        .virt_en     (in_virt_en),
        .fastcall_en (in_fastcall_en),
        .undef       (feat_undef),
        .dbg_eff     (idx_eff)
    );

    // invalid-opcode outranks a protection fault (R12)
    always_comb begin
        if (feat_undef)     verdict_d = VD_UD;
        else if (priv_deny) verdict_d = VD_PF;
        else                verdict_d = VD_ALLOW;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = in_valid ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_d = in_valid ? ST_REPORT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            verdict_q <= VD_ALLOW;
            idx_q     <= '0;
        end else if (in_valid) begin
            verdict_q <= verdict_d;
            idx_q     <= idx_eff;
        end
    end

    always_comb begin
        out_valid   = (state_q == ST_REPORT);
        out_verdict = verdict_q;
        out_dbg_idx = idx_q;
    end

    assert_result_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

    assert_verdict_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $onehot(out_verdict));

    assert_plain_allowed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_class == 3'd0)) |-> out_verdict == 3'b001);

    assert_ts_ring_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_class == 3'd1 && in_ts_lock && in_cpl != '0))
        |-> out_verdict == 3'b100);

    assert_alias_undef_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_class == 3'd3 && in_dbg_ext &&
                            (in_dbg_idx == DBG_W'(4) || in_dbg_idx == DBG_W'(5))))
        |-> out_verdict == 3'b010);

    assert_alias_remap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_class == 3'd3 && !in_dbg_ext && in_dbg_idx == DBG_W'(5)))
        |-> out_dbg_idx == DBG_W'(7));
endmodule

// File: tb/privop_permit_chk_tb_top.sv
module privop_permit_chk_tb_top;
    localparam int CPL_W = 2;
    localparam int DBG_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [2:0] in_class = '0;
    logic [CPL_W-1:0] in_cpl = '0;
    logic [DBG_W-1:0] in_dbg_idx = '0;
    logic in_ts_lock = 1'b0, in_ctr_open = 1'b0, in_dbg_ext = 1'b0;
    logic in_media_save = 1'b0, in_fpx_ok = 1'b0, in_virt_en = 1'b0, in_fastcall_en = 1'b0;
    logic out_valid;
    logic [2:0] out_verdict;
    logic [DBG_W-1:0] out_dbg_idx;

    typedef struct {
        logic [2:0]       verdict;
        logic [DBG_W-1:0] idx;
        string            tag;
    } exp_t;

    exp_t sb_q[$];
    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    privop_permit_chk #(.CPL_W(CPL_W), .DBG_W(DBG_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
        .in_cpl(in_cpl), .in_dbg_idx(in_dbg_idx), .in_ts_lock(in_ts_lock),
        .in_ctr_open(in_ctr_open), .in_dbg_ext(in_dbg_ext),
        .in_media_save(in_media_save), .in_fpx_ok(in_fpx_ok),
        .in_virt_en(in_virt_en), .in_fastcall_en(in_fastcall_en),
        .out_valid(out_valid), .out_verdict(out_verdict), .out_dbg_idx(out_dbg_idx)
    );

    function automatic string req_of(input logic [2:0] c);
        case (c)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6/R7";
            3'd4: return "R8";
            3'd5: return "R9";
            3'd6: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive one instruction; ctl bits: 0 ts_lock,1 ctr_open,2 dbg_ext,3 media_save,4 fpx_ok,5 virt_en,6 fastcall_en
    task automatic send(input logic [2:0] c, input logic [CPL_W-1:0] p,
                        input logic [DBG_W-1:0] ix, input logic [6:0] ctl);
        exp_t e;
        logic [2:0] v;
        logic [DBG_W-1:0] ei;
        @(negedge clk);
        in_valid = 1'b1; in_class = c; in_cpl = p; in_dbg_idx = ix;
        {in_fastcall_en, in_virt_en, in_fpx_ok, in_media_save, in_dbg_ext, in_ctr_open, in_ts_lock} = ctl;
        v = 3'b001;
        ei = ix;
        case (c)
            3'd1: if (ctl[0] && p != 0) v = 3'b100;
            3'd2: if (!ctl[1] && p != 0) v = 3'b100;
            3'd3: begin
                if (ctl[2]) begin
                    if (ix == 4 || ix == 5) v = 3'b010;
                end else if (ix == 4) ei = 6;
                else if (ix == 5) ei = 7;
            end
            3'd4: if (!ctl[3]) v = 3'b010;
            3'd5: if (!ctl[4]) v = 3'b010;
            3'd6: if (!ctl[5]) v = 3'b010;
            3'd7: if (!ctl[6]) v = 3'b010;
            default: v = 3'b001;
        endcase
        e.verdict = v; e.idx = ei; e.tag = req_of(c);
        sb_q.push_back(e);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        if (n > 1) repeat (n - 1) @(negedge clk);
    endtask

    // monitor: sample mid-high-phase after each rising edge
    always @(posedge clk) begin
        #5;
        if (rst_n && out_valid) begin
            if (sb_q.size() == 0) begin
                check("R1 unexpected result", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check({e.tag, " verdict (R2 onehot)"}, int'(out_verdict), int'(e.verdict));
                check({e.tag, " dbg index R7"}, int'(out_dbg_idx), int'(e.idx));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            check("watchdog", 1, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset out_valid", int'(out_valid), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 idle out_valid", int'(out_valid), 0);

        // every class, every privilege, several enable patterns (R12)
        foreach (sb_q[i]) ;
        for (int pat = 0; pat < 6; pat++) begin
            logic [6:0] ctl;
            case (pat)
                0: ctl = 7'h00;
                1: ctl = 7'h7f;
                2: ctl = 7'h55;
                3: ctl = 7'h2a;
                4: ctl = 7'h01;
                default: ctl = 7'h7e;
            endcase
            for (int c = 0; c < 8; c++)
                for (int p = 0; p < 4; p++)
                    send(3'(c), 2'(p), 3'(p + c), ctl);
        end
        idle(3);

        // every debug index with extensions on and off (R6, R7)
        for (int ext = 0; ext < 2; ext++)
            for (int ix = 0; ix < 8; ix++) begin
                send(3'd3, 2'd3, 3'(ix), ext ? 7'h04 : 7'h7b);
                if (ix == 3) idle(1);
            end
        // non-debug classes keep raw alias index (R7)
        send(3'd0, 2'd0, 3'd4, 7'h00);
        send(3'd6, 2'd1, 3'd5, 7'h20);
        idle(4);

        check("R1 drained out_valid", int'(out_valid), 0);
        check("R1 scoreboard empty", sb_q.size(), 0);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule